// File: doc/BRIEF.md
# Shader Program Upload Port

This block takes single-word register writes from a configuration bus and turns them into write strobes for four external memories: the vertex-unit instruction store, the vertex-unit swizzle-pattern store, the geometry-unit instruction store and the geometry-unit swizzle-pattern store. Each store has its own offset register. Software loads the offset register once and then streams words through a window of eight aliased data addresses. Every accepted word goes to the current offset, and the offset then steps forward by one, so a whole program can be uploaded without rewriting the address.

A word whose offset has already reached the depth of its store is dropped. No strobe is issued for it and a sticky error flag is raised, which stays set until a clear strobe. When the geometry unit is not configured for exclusive use (`geo_excl` low), each accepted vertex-unit word, whether instruction or swizzle pattern, is also written into the matching geometry-unit store at the same offset. The geometry offset registers are not touched by this copy. Writes aimed at the geometry stores are never copied back to the vertex stores.

All memory strobes come from registers: a bus write sampled at one clock edge appears on the memory ports during the cycle that follows. The error flag comes from a two-state machine with the states `ERR_CLEAN` and `ERR_HELD`. It goes from `ERR_CLEAN` to `ERR_HELD` on a dropped write. It goes back to `ERR_CLEAN` when `err_clr` is high and no write is dropped in that same cycle.

Top module: `shader_upload_port`

## Requirements
- R1: Address decode uses bus_addr[5:4] to pick the store (0 = vertex instruction, 1 = vertex swizzle, 2 = geometry instruction, 3 = geometry swizzle). Within each group of 16 addresses, local address 0 is the offset register and local addresses 8 to 15 are data addresses. All bits of bus_addr above bit 5 must be zero.
- R2: A write to an offset register loads bus_wdata[15:0] (OFS_W bits), ignores the upper data bits and issues no memory strobe. The next data write to that store uses the loaded value.
- R3: An accepted data write sampled at clock edge k raises that store's write strobe after edge k, for one cycle. The strobe carries the current offset and bus_wdata, and the offset then increments by one.
- R4: The eight data addresses of a store are interchangeable and share one offset register.
- R5: The vertex instruction store accepts offsets 0 to 511. The geometry instruction store accepts offsets 0 to 4095. Each swizzle store accepts offsets 0 to SWZ_DEPTH-1, with SWZ_DEPTH = 4096 by default.
- R6: A data write whose offset is at or beyond the store's depth issues no strobe, and no mirrored strobe either. err_flag is high after that edge.
- R7: err_flag stays high until err_clr is sampled high. If err_clr arrives in the same cycle as a dropped write, the flag stays high.
- R8: With geo_excl low, every accepted vertex instruction word is also strobed into the geometry instruction store at the same offset with the same data. The geometry instruction offset register is left unchanged.
- R9: With geo_excl low, every accepted vertex swizzle word is also strobed into the geometry swizzle store at the same offset with the same data.
- R10: With geo_excl high, vertex writes are not mirrored. Writes to geometry stores never produce a vertex-store strobe.
- R11: After reset all four strobes and err_flag are low and all four offsets are zero.
- R12: Writes to any address outside the R1 map (local addresses 1 to 7, or nonzero bits above bit 5) change no offset, issue no strobe and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus write request |
| bus_addr | input | 8 | Bus word address |
| bus_wdata | input | 32 | Bus write data |
| geo_excl | input | 1 | Geometry unit configured exclusively (disables mirroring) |
| err_clr | input | 1 | Clears the sticky error flag |
| vprog_we | output | 1 | Vertex instruction store write strobe |
| vprog_addr | output | 9 | Vertex instruction store address |
| vprog_data | output | 32 | Vertex instruction store data |
| vswz_we | output | 1 | Vertex swizzle store write strobe |
| vswz_addr | output | 12 | Vertex swizzle store address |
| vswz_data | output | 32 | Vertex swizzle store data |
| gprog_we | output | 1 | Geometry instruction store write strobe |
| gprog_addr | output | 12 | Geometry instruction store address |
| gprog_data | output | 32 | Geometry instruction store data |
| gswz_we | output | 1 | Geometry swizzle store write strobe |
| gswz_addr | output | 12 | Geometry swizzle store address |
| gswz_data | output | 32 | Geometry swizzle store data |
| err_flag | output | 1 | Sticky dropped-write flag |

## Verification
The upload path is tested with several kinds of stream:
- Single words and back-to-back words through different alias addresses. These distinguish a shared offset from one offset per alias.
- Vertex streams with mirroring on and then off, followed by a geometry write. These show whether the copy uses the vertex offset and leaves the geometry offset alone.
- Offsets placed at the last legal entry and one past it in each store. These separate the three depths.
- An out-of-range vertex offset that would still be legal for the geometry store. This catches a shared or wrong bound check.
- Writes to holes in the map and to aliases of the map with high address bits set. Each is followed by a real data write, which exposes any offset that was wrongly disturbed.

// File: rtl/shupl_pkg.sv
package shupl_pkg;

    localparam int WORD_W = 32;

    // store selected by bus_addr[5:4]
    typedef enum logic [1:0] {
        TGT_VPROG = 2'd0,
        TGT_VSWZ  = 2'd1,
        TGT_GPROG = 2'd2,
        TGT_GSWZ  = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_OFS  = 2'd1,
        ACC_DATA = 2'd2
    } acc_e;

    typedef struct packed {
        acc_e kind;
        tgt_e tgt;
    } dec_t;

    typedef enum logic {
        ERR_CLEAN = 1'b0,
        ERR_HELD  = 1'b1
    } err_st_e;

endpackage

// File: rtl/shupl_decode.sv
module shupl_decode
    import shupl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    localparam int HI_W = ADDR_W - 6;

    logic in_space;
    assign in_space = (addr[ADDR_W-1:6] == HI_W'(0));

    always_comb begin
        dec.tgt  = tgt_e'(addr[5:4]);
        dec.kind = ACC_NONE;
        if (we && in_space) begin
            if (addr[3]) begin
                dec.kind = ACC_DATA;
            end else if (addr[2:0] == 3'd0) begin
                dec.kind = ACC_OFS;
            end
        end
    end

endmodule

// File: rtl/shupl_offset.sv
module shupl_offset #(
    parameter int DEPTH = 512,
    parameter int OFS_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [OFS_W-1:0] ld_val,
    input  logic             wr,
    output logic             accept,
    output logic             drop,
    output logic [AW-1:0]    slot
);

    localparam logic [OFS_W:0] LIMIT = (OFS_W+1)'(DEPTH);

    logic [OFS_W-1:0] cur;
    logic             in_range;

    assign in_range = ({1'b0, cur} < LIMIT);
    assign accept   = wr && in_range;
    assign drop     = wr && !in_range;
    assign slot     = cur[AW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (ld) begin
            cur <= ld_val;
        end else if (accept) begin
            cur <= cur + OFS_W'(1);
        end
    end

endmodule

// File: rtl/shupl_wport.sv
module shupl_wport #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_o   <= 1'b0;
            addr_o <= '0;
            data_o <= '0;
        end else begin
            we_o <= en;
            if (en) begin
                addr_o <= addr;
                data_o <= data;
            end
        end
    end

endmodule

// File: rtl/shupl_err_fsm.sv
module shupl_err_fsm
    import shupl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    input  logic clr,
    output logic flag
);

    err_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ERR_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_CLEAN: if (drop)         state_d = ERR_HELD;
            ERR_HELD:  if (clr && !drop) state_d = ERR_CLEAN;
            default:                     state_d = ERR_CLEAN;
        endcase
    end

    always_comb begin
        flag = (state_q == ERR_HELD);
    end

endmodule

// File: rtl/shader_upload_port.sv
module shader_upload_port
    import shupl_pkg::*;
#(
    parameter int VP_DEPTH  = 512,
    parameter int GP_DEPTH  = 4096,
    parameter int SWZ_DEPTH = 4096,
    parameter int ADDR_W    = 8,
    parameter int OFS_W     = 16,
    localparam int VP_AW    = $clog2(VP_DEPTH),
    localparam int GP_AW    = $clog2(GP_DEPTH),
    localparam int SW_AW    = $clog2(SWZ_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              geo_excl,
    input  logic              err_clr,
    output logic              vprog_we,
    output logic [VP_AW-1:0]  vprog_addr,
    output logic [WORD_W-1:0] vprog_data,
    output logic              vswz_we,
    output logic [SW_AW-1:0]  vswz_addr,
    output logic [WORD_W-1:0] vswz_data,
    output logic              gprog_we,
    output logic [GP_AW-1:0]  gprog_addr,
    output logic [WORD_W-1:0] gprog_data,
    output logic              gswz_we,
    output logic [SW_AW-1:0]  gswz_addr,
    output logic [WORD_W-1:0] gswz_data,
    output logic              err_flag
);

    localparam int N_MEM   = 4;
    localparam int MAX_AW  = (GP_AW > SW_AW) ? GP_AW : SW_AW;

    dec_t              dec;
    logic [N_MEM-1:0]  ld_v, wr_v, acc_v, drop_v;
    logic [MAX_AW-1:0] slot [N_MEM];
    logic [N_MEM*MAX_AW-1:0] unused_slots;

    shupl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .we   (bus_we),
        .addr (bus_addr),
        .dec  (dec)
    );

    for (genvar i = 0; i < N_MEM; i++) begin : g_ofs
        localparam int DEP  = (i == 0) ? VP_DEPTH : ((i == 2) ? GP_DEPTH : SWZ_DEPTH);
        localparam int AW_I = $clog2(DEP);
        logic [AW_I-1:0] slot_i;

        assign ld_v[i] = (dec.kind == ACC_OFS)  && (dec.tgt == tgt_e'(2'(i)));
        assign wr_v[i] = (dec.kind == ACC_DATA) && (dec.tgt == tgt_e'(2'(i)));

        shupl_offset #(.DEPTH(DEP), .OFS_W(OFS_W)) u_ofs (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ld_v[i]),
            .ld_val (bus_wdata[OFS_W-1:0]),
            .wr     (wr_v[i]),
            .accept (acc_v[i]),
            .drop   (drop_v[i]),
            .slot   (slot_i)
        );

        assign slot[i] = MAX_AW'(slot_i);
    end

    assign unused_slots = {slot[3], slot[2], slot[1], slot[0]};

    // index 0 vertex instr, 1 vertex swizzle, 2 geometry instr, 3 geometry swizzle
    logic             mirror_prog, mirror_swz;
    logic             gp_en, gs_en;
    logic [GP_AW-1:0] gp_addr;
    logic [SW_AW-1:0] gs_addr;

    assign mirror_prog = acc_v[0] && !geo_excl;
    assign mirror_swz  = acc_v[1] && !geo_excl;
    assign gp_en       = acc_v[2] || mirror_prog;
    assign gs_en       = acc_v[3] || mirror_swz;
    assign gp_addr     = acc_v[2] ? slot[2][GP_AW-1:0] : GP_AW'(slot[0][VP_AW-1:0]);
    assign gs_addr     = acc_v[3] ? slot[3][SW_AW-1:0] : slot[1][SW_AW-1:0];

    shupl_wport #(.AW(VP_AW), .DW(WORD_W)) u_wp_vprog (
        .clk(clk), .rst_n(rst_n), .en(acc_v[0]), .addr(slot[0][VP_AW-1:0]),
        .data(bus_wdata), .we_o(vprog_we), .addr_o(vprog_addr), .data_o(vprog_data)
    );

    shupl_wport #(.AW(SW_AW), .DW(WORD_W)) u_wp_vswz (
        .clk(clk), .rst_n(rst_n), .en(acc_v[1]), .addr(slot[1][SW_AW-1:0]),
        .data(bus_wdata), .we_o(vswz_we), .addr_o(vswz_addr), .data_o(vswz_data)
    );

    shupl_wport #(.AW(GP_AW), .DW(WORD_W)) u_wp_gprog (
        .clk(clk), .rst_n(rst_n), .en(gp_en), .addr(gp_addr),
        .data(bus_wdata), .we_o(gprog_we), .addr_o(gprog_addr), .data_o(gprog_data)
    );

    shupl_wport #(.AW(SW_AW), .DW(WORD_W)) u_wp_gswz (
        .clk(clk), .rst_n(rst_n), .en(gs_en), .addr(gs_addr),
        .data(bus_wdata), .we_o(gswz_we), .addr_o(gswz_addr), .data_o(gswz_data)
    );

    shupl_err_fsm u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .drop  (|drop_v),
        .clr   (err_clr),
        .flag  (err_flag)
    );

endmodule

// File: rtl/shupl_chk.sv
module shupl_chk #(
    parameter int VP_AW = 9,
    parameter int GP_AW = 12,
    parameter int SW_AW = 12,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             geo_excl,
    input logic             err_clr,
    input logic             vprog_we,
    input logic [VP_AW-1:0] vprog_addr,
    input logic [DW-1:0]    vprog_data,
    input logic             vswz_we,
    input logic [SW_AW-1:0] vswz_addr,
    input logic [DW-1:0]    vswz_data,
    input logic             gprog_we,
    input logic [GP_AW-1:0] gprog_addr,
    input logic [DW-1:0]    gprog_data,
    input logic             gswz_we,
    input logic [SW_AW-1:0] gswz_addr,
    input logic [DW-1:0]    gswz_data,
    input logic             err_flag
);

    assert_prog_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vprog_we && !$past(geo_excl)) |->
            (gprog_we && gprog_addr == GP_AW'(vprog_addr) && gprog_data == vprog_data));

    assert_swz_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vswz_we && !$past(geo_excl)) |->
            (gswz_we && gswz_addr == vswz_addr && gswz_data == vswz_data));

    assert_no_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((vprog_we || vswz_we) && $past(geo_excl)) |-> (!gprog_we && !gswz_we));

    assert_one_vertex_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vprog_we, vswz_we}));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    assert_drop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> !(vprog_we || vswz_we || gprog_we || gswz_we));

endmodule

bind shader_upload_port shupl_chk #(
    .VP_AW(VP_AW), .GP_AW(GP_AW), .SW_AW(SW_AW), .DW(shupl_pkg::WORD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .geo_excl(geo_excl), .err_clr(err_clr),
    .vprog_we(vprog_we), .vprog_addr(vprog_addr), .vprog_data(vprog_data),
    .vswz_we(vswz_we), .vswz_addr(vswz_addr), .vswz_data(vswz_data),
    .gprog_we(gprog_we), .gprog_addr(gprog_addr), .gprog_data(gprog_data),
    .gswz_we(gswz_we), .gswz_addr(gswz_addr), .gswz_data(gswz_data),
    .err_flag(err_flag)
);

// File: tb/sim_shader_upload_port.sv
`timescale 1ns/1ps
module sim_shader_upload_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        geo_excl = 1'b1;
    logic        err_clr = 1'b0;
    logic        vprog_we, vswz_we, gprog_we, gswz_we, err_flag;
    logic [8:0]  vprog_addr;
    logic [11:0] vswz_addr, gprog_addr, gswz_addr;
    logic [31:0] vprog_data, vswz_data, gprog_data, gswz_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    // store bases: bits[5:4]; offset reg at +0, data window +8..+15
    localparam logic [7:0] VP = 8'h00, VS = 8'h10, GP = 8'h20, GS = 8'h30;

    always #2 clk = ~clk;

    shader_upload_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .geo_excl(geo_excl), .err_clr(err_clr),
        .vprog_we(vprog_we), .vprog_addr(vprog_addr), .vprog_data(vprog_data),
        .vswz_we(vswz_we), .vswz_addr(vswz_addr), .vswz_data(vswz_data),
        .gprog_we(gprog_we), .gprog_addr(gprog_addr), .gprog_data(gprog_data),
        .gswz_we(gswz_we), .gswz_addr(gswz_addr), .gswz_data(gswz_data),
        .err_flag(err_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic strobes(input string tag, input logic v, input logic vs,
                           input logic g, input logic gs);
        chk({tag, " strobes"}, {28'd0, vprog_we, vswz_we, gprog_we, gswz_we},
            {28'd0, v, vs, g, gs});
    endtask

    // called at a negedge; returns at the next negedge with results visible
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic t_reset();
        strobes("R11 reset", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11 reset err", {31'd0, err_flag}, 32'd0);
        geo_excl = 1'b1;
        wr(VP + 8'h08, 32'h1111_0000);
        chk("R11 vp offset zero", {23'd0, vprog_addr}, 32'd0);
        wr(VS + 8'h08, 32'h2222_0000);
        chk("R11 vs offset zero", {20'd0, vswz_addr}, 32'd0);
        wr(GP + 8'h08, 32'h3333_0000);
        chk("R11 gp offset zero", {20'd0, gprog_addr}, 32'd0);
        wr(GS + 8'h08, 32'h4444_0000);
        chk("R11 gs offset zero", {20'd0, gswz_addr}, 32'd0);
    endtask

    task automatic t_basic();
        geo_excl = 1'b1;
        wr(VP, 32'd5);
        strobes("R2 offset load silent", 1'b0, 1'b0, 1'b0, 1'b0);
        wr(VP + 8'h08, 32'hCAFE_0001);
        strobes("R3 vp write", 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R3 vp addr", {23'd0, vprog_addr}, 32'd5);
        chk("R3 vp data", vprog_data, 32'hCAFE_0001);
        wr(VP + 8'h0F, 32'hCAFE_0002);
        chk("R4 alias shares offset", {23'd0, vprog_addr}, 32'd6);
        chk("R4 alias data", vprog_data, 32'hCAFE_0002);
        wr(VP + 8'h0B, 32'hCAFE_0003);
        chk("R4 alias mid", {23'd0, vprog_addr}, 32'd7);
        wr(VP, 32'hABCD_0003);
        wr(VP + 8'h09, 32'h0000_0077);
        chk("R2 upper data bits ignored", {23'd0, vprog_addr}, 32'd3);
    endtask

    task automatic t_mirror_prog();
        geo_excl = 1'b1;
        wr(GP, 32'd100);
        geo_excl = 1'b0;
        wr(VP, 32'd10);
        wr(VP + 8'h0C, 32'h1234_5678);
        strobes("R8 mirrored", 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R8 mirror addr", {20'd0, gprog_addr}, 32'd10);
        chk("R8 mirror data", gprog_data, 32'h1234_5678);
        wr(VP + 8'h08, 32'h1234_5679);
        chk("R8 mirror addr next", {20'd0, gprog_addr}, 32'd11);
        wr(GP + 8'h0E, 32'h0BAD_F00D);
        strobes("R10 gp no back-mirror", 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 gp offset untouched", {20'd0, gprog_addr}, 32'd100);
        geo_excl = 1'b1;
        wr(VP + 8'h08, 32'h5555_5555);
        strobes("R10 exclusive no mirror", 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_mirror_swz();
        geo_excl = 1'b0;
        wr(VS, 32'd7);
        wr(VS + 8'h0A, 32'h00AB_CDEF);
        strobes("R9 swz mirrored", 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R9 vs addr", {20'd0, vswz_addr}, 32'd7);
        chk("R9 gs addr", {20'd0, gswz_addr}, 32'd7);
        chk("R9 gs data", gswz_data, 32'h00AB_CDEF);
        geo_excl = 1'b1;
        wr(VS + 8'h0D, 32'h0000_0042);
        strobes("R10 swz exclusive", 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9 vs addr step", {20'd0, vswz_addr}, 32'd8);
        geo_excl = 1'b0;
        wr(GS, 32'd300);
        wr(GS + 8'h0B, 32'h0000_0099);
        strobes("R10 gs no back-mirror", 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 gs own offset", {20'd0, gswz_addr}, 32'd300);
    endtask

    task automatic t_bounds();
        geo_excl = 1'b0;
        wr(VP, 32'd511);
        wr(VP + 8'h08, 32'hEEEE_0001);
        strobes("R5 vp last entry", 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R5 vp last addr", {23'd0, vprog_addr}, 32'd511);
        chk("R5 no err at last", {31'd0, err_flag}, 32'd0);
        wr(VP + 8'h08, 32'hEEEE_0002);
        strobes("R6 vp drop no strobe", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 vp drop err", {31'd0, err_flag}, 32'd1);
        clear_err();
        wr(VP, 32'd600);
        wr(VP + 8'h08, 32'hEEEE_0003);
        strobes("R5 vp 600 dropped", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5 vp 600 err", {31'd0, err_flag}, 32'd1);
        clear_err();
        geo_excl = 1'b1;
        wr(GP, 32'd600);
        wr(GP + 8'h08, 32'hEEEE_0004);
        chk("R5 gp 600 accepted", {20'd0, gprog_addr}, 32'd600);
        wr(GP, 32'd4095);
        wr(GP + 8'h08, 32'hEEEE_0005);
        strobes("R5 gp last", 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5 gp last addr", {20'd0, gprog_addr}, 32'd4095);
        wr(GP + 8'h08, 32'hEEEE_0006);
        strobes("R6 gp drop", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 gp drop err", {31'd0, err_flag}, 32'd1);
        clear_err();
        wr(VS, 32'd4095);
        wr(VS + 8'h08, 32'hEEEE_0007);
        chk("R5 vs last addr", {20'd0, vswz_addr}, 32'd4095);
        wr(VS + 8'h08, 32'hEEEE_0008);
        strobes("R6 vs drop", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 vs drop err", {31'd0, err_flag}, 32'd1);
        clear_err();
    endtask

    task automatic t_err();
        chk("R7 cleared", {31'd0, err_flag}, 32'd0);
        wr(GS, 32'd5000);
        wr(GS + 8'h08, 32'h1);
        chk("R7 set", {31'd0, err_flag}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R7 sticky", {31'd0, err_flag}, 32'd1);
        err_clr = 1'b1;
        wr(GS + 8'h08, 32'h2);
        err_clr = 1'b0;
        chk("R7 drop beats clear", {31'd0, err_flag}, 32'd1);
        clear_err();
        chk("R7 clear", {31'd0, err_flag}, 32'd0);
    endtask

    task automatic t_holes();
        geo_excl = 1'b1;
        wr(VP, 32'd20);
        wr(VP + 8'h03, 32'd0);
        strobes("R12 hole silent", 1'b0, 1'b0, 1'b0, 1'b0);
        wr(8'h48, 32'hDEAD_0001);
        strobes("R12 high alias silent", 1'b0, 1'b0, 1'b0, 1'b0);
        wr(8'h80, 32'd0);
        strobes("R12 high offset alias silent", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R12 no err", {31'd0, err_flag}, 32'd0);
        wr(VP + 8'h08, 32'hDEAD_0002);
        chk("R12 offset undisturbed", {23'd0, vprog_addr}, 32'd20);
        chk("R1 data ok", vprog_data, 32'hDEAD_0002);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mirror_prog();
        t_mirror_swz();
        t_bounds();
        t_err();
        t_holes();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule